// File: doc/BRIEF.md
# Strobe-Addressed System Control/Status Register

This block holds a 16-bit system control and status word. Software never writes data into it. Instead, every bit that software may change has its own set address and its own clear address. A write strobe to such an address changes that one bit, and no data bus is involved. Software therefore never needs a read-modify-write sequence, and two agents can never race on the same word.

Hardware also sets bits in the word. Three fault inputs set the bus-timeout, parity-error and alignment-fault bits. A timer interrupt pulse sets the clock-interrupt bit, which has its own clear input. Reads return either the whole word or one byte of it, with the high byte at the lower byte offset. A write strobe to one dedicated address sends a one-cycle system reset request downstream. The inhibit-timers bit is also driven out as a pin.

Bit map, from bit 0 to bit 15:

| Bit | Meaning |
| --- | --- |
| 0 | I/O fault |
| 1 | DMA |
| 2 | disk |
| 3 | serial |
| 4 | soft interrupt 9 |
| 5 | soft interrupt 8 |
| 6 | clock interrupt |
| 7 | inhibit faults |
| 8 | inhibit timers |
| 9 | floppy motor |
| 10 | spare |
| 11 | failure LED |
| 12 | alignment fault |
| 13 | reset request |
| 14 | parity error |
| 15 | bus timeout |

Top module: `sysctl_csr`

## Requirements
- R1: After reset the word is zero. A wide read at offset 0x02 then returns 0x0000, `inhibit_timers` is 0 and `sys_rst_req` is 0.
- R2: A read request at offset 0x02 with `rd_byte`=0 returns all 16 bits on `rd_data`. With `rd_byte`=1 it returns bits 15:8 in `rd_data[7:0]`, with zero above. A read at offset 0x03 returns bits 7:0, with zero above. `rd_valid` is high in the cycle after the request, and the data is the word as it stood at the request edge.
- R3: A read request at any offset other than 0x02 and 0x03 returns 0x0000.
- R4: Each write strobe below sets or clears one bit:

  | Bit | Set offset | Clear offset |
  | --- | --- | --- |
  | 11 (failure LED) | 0x13 | 0x17 |
  | 9 (floppy motor) | 0x1B | 0x1F |
  | 8 (inhibit timers) | 0x23 | 0x27 |
  | 7 (inhibit faults) | 0x2B | 0x2F |
  | 4 (soft interrupt 9) | 0x33 | 0x37 |
  | 5 (soft interrupt 8) | 0x3B | 0x3F |

  The change is visible from the next cycle.
- R5: A pulse on `hw_bus_timeout`, `hw_parity_err` or `hw_align_fault` sets bit 15, 14 or 12. Write strobes to 0x03, 0x07 and 0x0F clear those bits in the same order.
- R6: When a fault input and the software clear of the same bit arrive in the same cycle, the bit ends up set.
- R7: A write strobe to 0x0B drives `sys_rst_req` high for exactly the following cycle. It leaves the word unchanged.
- R8: A pulse on `tmr_irq` sets bit 6 only while bit 8 is 0. A pulse on `clk_irq_clr` clears bit 6. If both arrive in the same cycle, bit 6 ends up set.
- R9: `inhibit_timers` follows bit 8 of the word.
- R10: A write strobe to any offset not listed in R4, R5 or R7 leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset, shared by reads and writes |
| wr_en | input | 1 | Write strobe at `addr` |
| rd_en | input | 1 | Read request at `addr` |
| rd_byte | input | 1 | 1 selects a byte read, 0 a wide read |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | `rd_data` is valid |
| hw_bus_timeout | input | 1 | Sets bit 15 |
| hw_parity_err | input | 1 | Sets bit 14 |
| hw_align_fault | input | 1 | Sets bit 12 |
| tmr_irq | input | 1 | Timer interrupt pulse, sets bit 6 |
| clk_irq_clr | input | 1 | Clears bit 6 |
| sys_rst_req | output | 1 | One-cycle system reset request |
| inhibit_timers | output | 1 | Copy of bit 8 |

## Verification
The assertions assume inputs that are synchronous to `clk` and stable across each rising edge. They also assume that `addr` is meaningful whenever `wr_en` is high. The idle-hold property further assumes that nothing but a write strobe or a hardware input changes the word.

The bench drives every input at the falling edge and never raises `wr_en` and `rd_en` together. Each read therefore sees a word that no other event is changing at the same edge. Hardware pulses are applied either alone or, for the priority cases, together with the single clear they compete against.

// File: rtl/sysctl_csr_pkg.sv
package sysctl_csr_pkg;
    localparam int CSR_W = 16;

    localparam int IDX_SOFT9    = 4;
    localparam int IDX_SOFT8    = 5;
    localparam int IDX_CLKINT   = 6;
    localparam int IDX_INH_FLT  = 7;
    localparam int IDX_INH_TMR  = 8;
    localparam int IDX_MOTOR    = 9;
    localparam int IDX_FAIL_LED = 11;
    localparam int IDX_ALIGN    = 12;
    localparam int IDX_PARITY   = 14;
    localparam int IDX_BUS_TO   = 15;

    typedef logic [CSR_W-1:0] csr_word_t;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_WIDE = 2'd1,
        RD_HIGH = 2'd2,
        RD_LOW  = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/csr_wr_decode.sv
module csr_wr_decode
    import sysctl_csr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output csr_word_t         sw_set,
    output csr_word_t         sw_clr,
    output logic              rst_strobe
);
    always_comb begin
        sw_set     = '0;
        sw_clr     = '0;
        rst_strobe = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_W'(8'h03): sw_clr[IDX_BUS_TO]   = 1'b1;
                ADDR_W'(8'h07): sw_clr[IDX_PARITY]   = 1'b1;
                ADDR_W'(8'h0B): rst_strobe           = 1'b1;
                ADDR_W'(8'h0F): sw_clr[IDX_ALIGN]    = 1'b1;
                ADDR_W'(8'h13): sw_set[IDX_FAIL_LED] = 1'b1;
                ADDR_W'(8'h17): sw_clr[IDX_FAIL_LED] = 1'b1;
                ADDR_W'(8'h1B): sw_set[IDX_MOTOR]    = 1'b1;
                ADDR_W'(8'h1F): sw_clr[IDX_MOTOR]    = 1'b1;
                ADDR_W'(8'h23): sw_set[IDX_INH_TMR]  = 1'b1;
                ADDR_W'(8'h27): sw_clr[IDX_INH_TMR]  = 1'b1;
                ADDR_W'(8'h2B): sw_set[IDX_INH_FLT]  = 1'b1;
                ADDR_W'(8'h2F): sw_clr[IDX_INH_FLT]  = 1'b1;
                ADDR_W'(8'h33): sw_set[IDX_SOFT9]    = 1'b1;
                ADDR_W'(8'h37): sw_clr[IDX_SOFT9]    = 1'b1;
                ADDR_W'(8'h3B): sw_set[IDX_SOFT8]    = 1'b1;
                ADDR_W'(8'h3F): sw_clr[IDX_SOFT8]    = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/csr_bit_store.sv
module csr_bit_store
    import sysctl_csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  csr_word_t set_m,
    input  csr_word_t clr_m,
    output csr_word_t q
);
    for (genvar i = 0; i < CSR_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (set_m[i]) q[i] <= 1'b1;
            else if (clr_m[i]) q[i] <= 1'b0;
        end

        // R6: a set request wins over a clear in the same cycle
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_m[i] |=> q[i]);
        a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_m[i] && !set_m[i]) |=> !q[i]);
    end
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
    import sysctl_csr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_byte,
    input  logic [ADDR_W-1:0] addr,
    input  csr_word_t         word,
    output csr_word_t         rd_data,
    output logic              rd_valid
);
    rd_sel_e sel;

    always_comb begin
        if (addr == ADDR_W'(8'h02))      sel = rd_byte ? RD_HIGH : RD_WIDE;
        else if (addr == ADDR_W'(8'h03)) sel = RD_LOW;
        else                             sel = RD_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                unique case (sel)
                    RD_WIDE: rd_data <= word;
                    RD_HIGH: rd_data <= {8'h00, word[15:8]};
                    RD_LOW:  rd_data <= {8'h00, word[7:0]};
                    RD_NONE: rd_data <= '0;
                endcase
            end
        end
    end

    // R3: an off-map read returns zero
    a_r3_offmap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != ADDR_W'(8'h02) && addr != ADDR_W'(8'h03)) |=> (rd_data == '0));
endmodule

// File: rtl/sysctl_csr.sv
module sysctl_csr
    import sysctl_csr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rd_byte,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    input  logic              hw_bus_timeout,
    input  logic              hw_parity_err,
    input  logic              hw_align_fault,
    input  logic              tmr_irq,
    input  logic              clk_irq_clr,
    output logic              sys_rst_req,
    output logic              inhibit_timers
);
    csr_word_t sw_set, sw_clr, hw_set, hw_clr, word;
    logic      rst_strobe;

    csr_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .addr(addr),
        .sw_set(sw_set), .sw_clr(sw_clr), .rst_strobe(rst_strobe)
    );

    always_comb begin
        hw_set              = '0;
        hw_clr              = '0;
        hw_set[IDX_BUS_TO]  = hw_bus_timeout;
        hw_set[IDX_PARITY]  = hw_parity_err;
        hw_set[IDX_ALIGN]   = hw_align_fault;
        hw_set[IDX_CLKINT]  = tmr_irq & ~word[IDX_INH_TMR];
        hw_clr[IDX_CLKINT]  = clk_irq_clr;
    end

    csr_bit_store u_store (
        .clk(clk), .rst_n(rst_n),
        .set_m(sw_set | hw_set), .clr_m(sw_clr | hw_clr), .q(word)
    );

    csr_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_byte(rd_byte),
        .addr(addr), .word(word), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_rst_req <= 1'b0;
        else        sys_rst_req <= rst_strobe;
    end

    assign inhibit_timers = word[IDX_INH_TMR];

    // R7: a reset request only follows a write strobe
    a_r7_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(wr_en));
    // R8: timer pulse ignored while timers are inhibited
    a_r8_timer_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_irq && word[IDX_INH_TMR] && !word[IDX_CLKINT]) |=> !word[IDX_CLKINT]);
    // R10: with no strobe and no hardware event the word holds
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !hw_bus_timeout && !hw_parity_err && !hw_align_fault
         && !tmr_irq && !clk_irq_clr) |=> $stable(word));
    // R4: set strobe for the failure LED bit
    a_r4_led_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h13)) |=> word[IDX_FAIL_LED]);
endmodule

// File: tb/sysctl_csr_tb_top.sv
module sysctl_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rd_byte = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        hw_bus_timeout = 1'b0, hw_parity_err = 1'b0, hw_align_fault = 1'b0;
    logic        tmr_irq = 1'b0, clk_irq_clr = 1'b0;
    logic        sys_rst_req, inhibit_timers;

    int          n_checks = 0, n_fail = 0;
    logic [15:0] model = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    sysctl_csr #(.ADDR_W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .rd_byte(rd_byte), .rd_data(rd_data), .rd_valid(rd_valid),
        .hw_bus_timeout(hw_bus_timeout), .hw_parity_err(hw_parity_err),
        .hw_align_fault(hw_align_fault), .tmr_irq(tmr_irq),
        .clk_irq_clr(clk_irq_clr), .sys_rst_req(sys_rst_req),
        .inhibit_timers(inhibit_timers)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench model of the write strobes, taken from R4, R5, R7 and R10
    function automatic logic [15:0] apply_wr(input logic [15:0] m, input logic [5:0] a);
        case (a)
            6'h03: m[15] = 1'b0;  6'h07: m[14] = 1'b0;  6'h0F: m[12] = 1'b0;
            6'h13: m[11] = 1'b1;  6'h17: m[11] = 1'b0;
            6'h1B: m[9]  = 1'b1;  6'h1F: m[9]  = 1'b0;
            6'h23: m[8]  = 1'b1;  6'h27: m[8]  = 1'b0;
            6'h2B: m[7]  = 1'b1;  6'h2F: m[7]  = 1'b0;
            6'h33: m[4]  = 1'b1;  6'h37: m[4]  = 1'b0;
            6'h3B: m[5]  = 1'b1;  6'h3F: m[5]  = 1'b0;
            default: ;
        endcase
        return m;
    endfunction

    task automatic wr(input logic [5:0] a);
        @(negedge clk);
        wr_en = 1'b1; addr = a;
        @(negedge clk);
        wr_en = 1'b0;
        model = apply_wr(model, a);
        if (a == 6'h0B) begin
            check("R7 req pulse", {15'd0, sys_rst_req}, 16'd1);
            @(negedge clk);
            check("R7 req one cycle", {15'd0, sys_rst_req}, 16'd0);
        end
    endtask

    // Driver: issue a read and push the expected word into the scoreboard
    task automatic rd(input logic [5:0] a, input logic byte_sel, input string req);
        logic [15:0] e;
        @(negedge clk);
        rd_en = 1'b1; addr = a; rd_byte = byte_sel;
        if (a == 6'h02) e = byte_sel ? {8'h00, model[15:8]} : model;
        else if (a == 6'h03) e = {8'h00, model[7:0]};
        else e = 16'h0000;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic hw(input logic to, input logic pe, input logic al,
                      input logic ti, input logic cc, input logic [5:0] wa, input logic we);
        @(negedge clk);
        hw_bus_timeout = to; hw_parity_err = pe; hw_align_fault = al;
        tmr_irq = ti; clk_irq_clr = cc; wr_en = we; addr = wa;
        @(negedge clk);
        hw_bus_timeout = 1'b0; hw_parity_err = 1'b0; hw_align_fault = 1'b0;
        tmr_irq = 1'b0; clk_irq_clr = 1'b0; wr_en = 1'b0;
        if (we) model = apply_wr(model, wa);
        if (to) model[15] = 1'b1;
        if (pe) model[14] = 1'b1;
        if (al) model[12] = 1'b1;
        if (cc) model[6] = 1'b0;
        if (ti && !model[8]) model[6] = 1'b1;
    endtask

    // Monitor: pop and compare as read results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R2 unexpected read actual=%h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 inhibit", {15'd0, inhibit_timers}, 16'd0);
        check("R1 reset req", {15'd0, sys_rst_req}, 16'd0);
        rd(6'h02, 1'b0, "R1 reset word");
        wr(6'h13); wr(6'h33); wr(6'h1B);
        rd(6'h02, 1'b0, "R4 sets wide");
        rd(6'h02, 1'b1, "R2 high byte");
        rd(6'h03, 1'b0, "R2 low byte");
        rd(6'h03, 1'b1, "R2 low byte flag");
        rd(6'h00, 1'b0, "R3 offset 0");
        rd(6'h13, 1'b0, "R3 offset 13");
        wr(6'h3B); wr(6'h2B); wr(6'h37); wr(6'h1F);
        rd(6'h02, 1'b0, "R4 mixed");
        wr(6'h05); wr(6'h10); wr(6'h3E);
        rd(6'h02, 1'b0, "R10 unlisted");
        wr(6'h0B);
        rd(6'h02, 1'b0, "R7 word kept");
        hw(1, 1, 1, 0, 0, 6'h00, 0);
        rd(6'h02, 1'b0, "R5 faults set");
        wr(6'h07);
        rd(6'h02, 1'b0, "R5 parity cleared");
        hw(0, 0, 0, 0, 0, 6'h03, 1);
        hw(0, 0, 0, 0, 0, 6'h0F, 1);
        rd(6'h02, 1'b0, "R5 all cleared");
        hw(1, 0, 0, 0, 0, 6'h03, 1);
        rd(6'h02, 1'b0, "R6 timeout wins");
        hw(0, 0, 1, 0, 0, 6'h0F, 1);
        rd(6'h03, 1'b0, "R6 align wins low");
        rd(6'h02, 1'b1, "R6 align wins high");
        hw(0, 0, 0, 1, 0, 6'h00, 0);
        rd(6'h03, 1'b0, "R8 clock set");
        hw(0, 0, 0, 0, 1, 6'h00, 0);
        rd(6'h03, 1'b0, "R8 clock cleared");
        hw(0, 0, 0, 1, 1, 6'h00, 0);
        rd(6'h03, 1'b0, "R8 set beats clear");
        hw(0, 0, 0, 0, 1, 6'h00, 0);
        wr(6'h23);
        @(negedge clk);
        check("R9 inhibit high", {15'd0, inhibit_timers}, 16'd1);
        hw(0, 0, 0, 1, 0, 6'h00, 0);
        rd(6'h02, 1'b0, "R8 blocked by inhibit");
        wr(6'h27);
        @(negedge clk);
        check("R9 inhibit low", {15'd0, inhibit_timers}, 16'd0);
        rd(6'h02, 1'b0, "R4 final");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule